// File: doc/BRIEF.md
# Length-Steered Serial Register Loader

This block is the write side of a three-wire serial port: a data line, a serial clock and an active-low enable. It has no address field. The destination is chosen by how many bits were clocked in between the falling and the rising edge of enable. The block keeps three destinations:

- a short configuration register;
- a reference register, whose upper few bits act at once and whose lower bits pass through a staging buffer before they reach an active copy;
- a long main register.

The staged reference bits move to the active copy when a main-register frame commits, so that the new reference and main values appear in the same cycle. An enable pulse with no clock edges moves them on its own.

The serial pins are not used as clocks. Each pin goes through a synchronizer into the system clock domain, and edges are found by comparing consecutive samples. The system clock must run at least four times faster than the serial clock. Once the enable edge has been seen, a frame commits one system cycle later. An optional data-out pin presents the top bit of the shift register after each falling serial edge. An enable edge that arrives while the serial clock is high spoils the frame. The port recovers once enable is high and the serial clock is low.

Top module: `lenstr_loader`

## Requirements
- R1: Bits enter the shift register most significant first, one per rising serial-clock edge seen while enable is low. A 24-bit value therefore lands with the first bit sent at bit 23 of `main_q`.
- R2: A frame of exactly CFG_W (8) bits writes `cfg_q` with the frame's bits, the first bit sent landing at bit 7.
- R3: No destination or buffer changes while a frame is being shifted. Updates happen only after the enable rising edge is detected.
- R4: A frame of exactly REF_W (16) bits writes frame bits 15..13 into `ref_hi_q` at once. Frame bits 12..0 go into the staging buffer only, and `ref_act_q` keeps its value.
- R5: A frame of exactly MAIN_W (24) bits writes `main_q`. In the same cycle it copies the staging buffer as it stood before the frame into `ref_act_q`.
- R6: An enable low pulse with no serial-clock edges copies the staging buffer into `ref_act_q` and changes nothing else.
- R7: A frame of any other length, including lengths from 25 to 32, changes nothing. The bit count saturates at MAX_BITS+1 (33), so longer frames also change nothing.
- R8: A frame changes nothing if enable falls or rises while the serial clock is high. The next frame that starts with enable high and the serial clock low is accepted normally.
- R9: With HAS_DOUT set, `ser_dout` takes bit 23 of the shift register on each falling serial edge while enable is low, and holds it otherwise. The shift register is cleared while enable is high, so after a 24-bit frame `ser_dout` shows the frame's first bit.
- R10: While `rst_n` is low, every register, buffer and output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_en_n | input | 1 | Serial enable, active low, asynchronous |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out (top shift-register bit) |
| cfg_q | output | 8 | Configuration register |
| ref_hi_q | output | 3 | Immediate upper reference bits |
| ref_act_q | output | 13 | Active (second-stage) lower reference bits |
| main_q | output | 24 | Main register |

## Verification
The bench builds the block with its default parameters:

- widths 8, 16 and 24, with 13 staged reference bits;
- a two-stage synchronizer;
- a MAX_BITS of 32;
- data-out enabled.

Every legal frame length can be reached with these values, as can the gap between the staged and the active reference copy. A 40-bit frame drives the bit counter into saturation, and a 32-bit frame tests the upper edge of the illegal range. Having the data-out pin present means its value can be predicted from the first bit of each 24-bit frame.

// File: rtl/lenstr_pkg.sv
package lenstr_pkg;
   typedef enum logic [2:0] {
      CMT_NONE = 3'd0,
      CMT_CFG  = 3'd1,
      CMT_REF  = 3'd2,
      CMT_MAIN = 3'd3,
      CMT_XFER = 3'd4
   } cmt_e;
endpackage

// File: rtl/lenstr_sync.sv
module lenstr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lenstr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/lenstr_shifter.sv
module lenstr_shifter
   import lenstr_pkg::*;
#(
   parameter int CFG_W    = 8,
   parameter int REF_W    = 16,
   parameter int MAIN_W   = 24,
   parameter int MAX_BITS = 32,
   parameter bit HAS_DOUT = 1'b1,
   localparam int SAT     = MAX_BITS + 1,
   localparam int CNT_W   = $clog2(MAX_BITS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              en_n_s,
   input  logic              din_s,
   output logic [MAIN_W-1:0] shreg,
   output cmt_e              cmt,
   output logic              dout,
   output logic              en_rise,
   output logic              frame_bad,
   output logic [CNT_W-1:0]  bit_cnt
);
   logic sclk_prev, en_prev;
   logic sclk_rise, sclk_fall, en_fall, en_edge;

   always_comb begin
      sclk_rise = sclk_s & ~sclk_prev;
      sclk_fall = ~sclk_s & sclk_prev;
      en_rise   = en_n_s & ~en_prev;
      en_fall   = ~en_n_s & en_prev;
      en_edge   = en_rise | en_fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         en_prev   <= 1'b1;
      end else begin
         sclk_prev <= sclk_s;
         en_prev   <= en_n_s;
      end
   end

   // violation tracking: set on an enable edge with serial clock high,
   // cleared once idle with serial clock low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             frame_bad <= 1'b0;
      else if (en_edge && sclk_s)             frame_bad <= 1'b1;
      else if (en_n_s && !sclk_s && !en_rise) frame_bad <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (en_n_s) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (sclk_rise) begin
         shreg <= {shreg[MAIN_W-2:0], din_s};
         if (bit_cnt != CNT_W'(SAT)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_comb begin
      cmt = CMT_NONE;
      if (en_rise && !frame_bad && !sclk_s) begin
         if      (bit_cnt == CNT_W'(CFG_W))  cmt = CMT_CFG;
         else if (bit_cnt == CNT_W'(REF_W))  cmt = CMT_REF;
         else if (bit_cnt == CNT_W'(MAIN_W)) cmt = CMT_MAIN;
         else if (bit_cnt == '0)             cmt = CMT_XFER;
      end
   end

   if (HAS_DOUT) begin : g_dout
      logic dout_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   dout_q <= 1'b0;
         else if (!en_n_s && sclk_fall) dout_q <= shreg[MAIN_W-1];
      end
      assign dout = dout_q;
   end else begin : g_no_dout
      assign dout = 1'b0;
   end
endmodule

// File: rtl/lenstr_regs.sv
module lenstr_regs
   import lenstr_pkg::*;
#(
   parameter int CFG_W    = 8,
   parameter int REF_W    = 16,
   parameter int MAIN_W   = 24,
   parameter int REF_DB_W = 13,
   localparam int HI_W    = REF_W - REF_DB_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cmt_e                cmt,
   input  logic [MAIN_W-1:0]   shreg,
   output logic [CFG_W-1:0]    cfg_q,
   output logic [HI_W-1:0]     ref_hi_q,
   output logic [REF_DB_W-1:0] ref_act_q,
   output logic [MAIN_W-1:0]   main_q
);
   logic [REF_DB_W-1:0] ref_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         ref_hi_q  <= '0;
         ref_stage <= '0;
         ref_act_q <= '0;
         main_q    <= '0;
      end else begin
         unique case (cmt)
            CMT_CFG:  cfg_q <= shreg[CFG_W-1:0];
            CMT_REF: begin
               ref_hi_q  <= shreg[REF_W-1:REF_DB_W];
               ref_stage <= shreg[REF_DB_W-1:0];
            end
            CMT_MAIN: begin
               main_q    <= shreg;
               ref_act_q <= ref_stage;
            end
            CMT_XFER: ref_act_q <= ref_stage;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lenstr_loader.sv
module lenstr_loader
   import lenstr_pkg::*;
#(
   parameter int CFG_W       = 8,
   parameter int REF_W       = 16,
   parameter int MAIN_W      = 24,
   parameter int REF_DB_W    = 13,
   parameter int MAX_BITS    = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_DOUT    = 1'b1,
   localparam int HI_W       = REF_W - REF_DB_W,
   localparam int CNT_W      = $clog2(MAX_BITS + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_en_n,
   input  logic                ser_din,
   output logic                ser_dout,
   output logic [CFG_W-1:0]    cfg_q,
   output logic [HI_W-1:0]     ref_hi_q,
   output logic [REF_DB_W-1:0] ref_act_q,
   output logic [MAIN_W-1:0]   main_q
);
   if (!(CFG_W < REF_W && REF_W < MAIN_W)) begin : g_bad_widths
      $error("lenstr_loader: widths must satisfy CFG_W < REF_W < MAIN_W");
   end
   if (REF_DB_W < 1 || REF_DB_W >= REF_W) begin : g_bad_db
      $error("lenstr_loader: REF_DB_W must lie in 1..REF_W-1");
   end
   if (MAX_BITS < MAIN_W) begin : g_bad_max
      $error("lenstr_loader: MAX_BITS must cover MAIN_W");
   end

   logic sclk_s, en_n_s, din_s;
   logic [MAIN_W-1:0] shreg_w;
   cmt_e cmt_w;
   logic en_rise_w, frame_bad_w;
   logic [CNT_W-1:0] bit_cnt_w;

   lenstr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
   lenstr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(ser_en_n), .q(en_n_s));
   lenstr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(ser_din), .q(din_s));

   lenstr_shifter #(
      .CFG_W(CFG_W), .REF_W(REF_W), .MAIN_W(MAIN_W),
      .MAX_BITS(MAX_BITS), .HAS_DOUT(HAS_DOUT)
   ) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .en_n_s(en_n_s), .din_s(din_s),
      .shreg(shreg_w), .cmt(cmt_w), .dout(ser_dout),
      .en_rise(en_rise_w), .frame_bad(frame_bad_w), .bit_cnt(bit_cnt_w)
   );

   lenstr_regs #(
      .CFG_W(CFG_W), .REF_W(REF_W), .MAIN_W(MAIN_W), .REF_DB_W(REF_DB_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cmt(cmt_w), .shreg(shreg_w),
      .cfg_q(cfg_q), .ref_hi_q(ref_hi_q), .ref_act_q(ref_act_q), .main_q(main_q)
   );
endmodule

// File: rtl/lenstr_checker.sv
module lenstr_checker
   import lenstr_pkg::*;
#(
   parameter int CFG_W    = 8,
   parameter int REF_W    = 16,
   parameter int MAIN_W   = 24,
   parameter int REF_DB_W = 13,
   parameter int MAX_BITS = 32,
   localparam int HI_W    = REF_W - REF_DB_W,
   localparam int CNT_W   = $clog2(MAX_BITS + 2)
) (
   input logic                clk,
   input logic                rst_n,
   input cmt_e                cmt,
   input logic                en_rise,
   input logic                frame_bad,
   input logic [CNT_W-1:0]    bit_cnt,
   input logic [CFG_W-1:0]    cfg_q,
   input logic [HI_W-1:0]     ref_hi_q,
   input logic [REF_DB_W-1:0] ref_act_q,
   input logic [MAIN_W-1:0]   main_q
);
   // R2: configuration changes only after a configuration commit
   a_r2_cfg_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> $past(cmt == CMT_CFG));
   // R4: immediate reference bits change only after a reference commit
   a_r4_hi_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_hi_q) |-> $past(cmt == CMT_REF));
   // R5 and R6: active reference changes only on main or empty frame
   a_r5_act_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_act_q) |-> $past(cmt == CMT_MAIN || cmt == CMT_XFER));
   // R3: main register changes only after a main commit
   a_r3_main_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(main_q) |-> $past(cmt == CMT_MAIN));
   // R7: bit counter never passes its saturation value
   a_r7_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(MAX_BITS + 1));
   // R8: a spoiled frame leaves every destination alone
   a_r8_bad_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rise && frame_bad) |=> ($stable(cfg_q) && $stable(main_q)
                                  && $stable(ref_hi_q) && $stable(ref_act_q)));
   // R3: commits only occur at the end of a frame
   a_r3_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt != CMT_NONE) |-> en_rise);
endmodule

bind lenstr_loader lenstr_checker #(
   .CFG_W(CFG_W), .REF_W(REF_W), .MAIN_W(MAIN_W),
   .REF_DB_W(REF_DB_W), .MAX_BITS(MAX_BITS)
) u_lenstr_chk (
   .clk(clk), .rst_n(rst_n), .cmt(cmt_w), .en_rise(en_rise_w),
   .frame_bad(frame_bad_w), .bit_cnt(bit_cnt_w),
   .cfg_q(cfg_q), .ref_hi_q(ref_hi_q), .ref_act_q(ref_act_q), .main_q(main_q)
);

// File: tb/lenstr_loader_bench.sv
module lenstr_loader_bench;
   localparam int PH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
   logic ser_dout;
   logic [7:0]  cfg_q;
   logic [2:0]  ref_hi_q;
   logic [12:0] ref_act_q;
   logic [23:0] main_q;

   always #5 clk = ~clk;

   lenstr_loader u_lenstr_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
      .ser_din(ser_din), .ser_dout(ser_dout), .cfg_q(cfg_q),
      .ref_hi_q(ref_hi_q), .ref_act_q(ref_act_q), .main_q(main_q));

   typedef struct {
      logic [7:0]  cfg;
      logic [2:0]  hi;
      logic [12:0] act;
      logic [23:0] main;
      logic        dout;
      bit          chk_dout;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   event frame_done;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference model
   logic [7:0]  m_cfg = '0;
   logic [2:0]  m_hi = '0;
   logic [12:0] m_stage = '0, m_act = '0;
   logic [23:0] m_main = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_ph();
      repeat (PH) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_din = b;
      wait_ph();
      ser_clk = 1'b1;
      wait_ph();
      ser_clk = 1'b0;
   endtask

   // viol: 0 clean, 1 enable falls with clock high, 2 enable rises with clock high
   task automatic frame(input logic [63:0] data, input int n, input int viol, input string tag);
      exp_t it;
      if (viol == 1) begin ser_clk = 1'b1; wait_ph(); end
      ser_en_n = 1'b0;
      wait_ph();
      if (viol == 1) begin ser_clk = 1'b0; wait_ph(); end
      for (int i = n - 1; i >= 0; i--) begin
         send_bit(data[i]);
         if (n == 24 && viol == 0 && i == 12)
            chk("R3 main held mid-frame", 32'(main_q), 32'(m_main));
      end
      wait_ph();
      if (viol == 2) begin ser_clk = 1'b1; wait_ph(); end
      ser_en_n = 1'b1;
      wait_ph();
      ser_clk = 1'b0;
      it.chk_dout = 1'b0;
      it.dout = 1'b0;
      if (viol == 0) begin
         case (n)
            8:  m_cfg = data[7:0];
            16: begin m_hi = data[15:13]; m_stage = data[12:0]; end
            24: begin m_main = data[23:0]; m_act = m_stage;
                      it.chk_dout = 1'b1; it.dout = data[23]; end
            0:  m_act = m_stage;
            default: ;
         endcase
      end
      it.cfg = m_cfg; it.hi = m_hi; it.act = m_act; it.main = m_main; it.tag = tag;
      sb_q.push_back(it);
      -> frame_done;
      repeat (16) @(negedge clk);
   endtask

   // monitor
   initial begin
      forever begin
         exp_t it;
         @(frame_done);
         repeat (8) @(negedge clk);
         it = sb_q.pop_front();
         chk({it.tag, " cfg"},  32'(cfg_q),     32'(it.cfg));
         chk({it.tag, " hi"},   32'(ref_hi_q),  32'(it.hi));
         chk({it.tag, " act"},  32'(ref_act_q), 32'(it.act));
         chk({it.tag, " main"}, 32'(main_q),    32'(it.main));
         if (it.chk_dout) chk({it.tag, " R9 dout"}, 32'(ser_dout), 32'(it.dout));
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 cfg in reset", 32'(cfg_q), 0);
      chk("R10 main in reset", 32'(main_q), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 act after reset", 32'(ref_act_q), 0);
      chk("R10 dout after reset", 32'(ser_dout), 0);

      frame(64'hA5, 8, 0, "R2 cfg frame");
      frame(64'hE123, 16, 0, "R4 ref frame");
      frame(64'h9ABCDE, 24, 0, "R5 R1 main frame");
      frame(64'h2456, 16, 0, "R4 second ref frame");
      frame(64'h0, 0, 0, "R6 empty pulse");
      frame(64'hFFF, 12, 0, "R7 12-bit");
      frame(64'hDEADBEEF, 32, 0, "R7 32-bit");
      frame(64'h12_3456_789A, 40, 0, "R7 40-bit sat");
      frame(64'h5A, 8, 1, "R8 start high");
      frame(64'h5A, 8, 2, "R8 end high");
      frame(64'h3C, 8, 0, "R8 resync cfg");
      frame(64'h7FF0F0, 24, 0, "R9 R1 main low msb");
      frame(64'h1FFF, 16, 0, "R4 R3 ref stage only");
      frame(64'h800001, 24, 0, "R5 R9 main commit");
      repeat (20) @(negedge clk);
      finish_run();
   end
endmodule